// File: doc/BRIEF.md
# Multistage Omega Switching Network

This block links N processor ports to N memory-module ports through log2(N) columns of two-by-two switches. The columns are joined by perfect-shuffle wiring. A processor presents a byte address, a write flag and a data word. The module number is taken from the word-address bits just above the byte offset, so consecutive words are spread across consecutive modules. Each column steers a packet on one bit of that number, starting with the most significant bit. A 0 bit sends the packet to the upper output and a 1 bit sends it to the lower output. The switch then overwrites that bit with the number of the input the packet entered on. When the packet reaches its module, the route field therefore holds the number of the processor that sent it.

Answers travel back through a second network of the same shape. The memory side hands back the route field it received, together with a write flag and data. Each column consumes one bit of that field and rewrites it with its own input number. When the answer reaches the processor, the field names the module that produced it.

A switch keeps nothing about a packet once the packet has left. Every switch output is one register stage with a valid/ready handshake. Two packets that need the same output in the same cycle do not both pass. The output alternates between its two inputs, and the losing packet waits at its input.

Top module: `omega_net`

## Requirements
- R1: A request from any processor leaves on memory port `addr[4:2]` (bits `BYTE_OFF` upward, `log2(N)` wide). Its address, data and write flag arrive unchanged.
- R2: Address bits 1:0 never affect the chosen module, and eight consecutive word addresses reach modules 0 to 7 in turn.
- R3: `mem_req_src` on a delivered request equals the number of the processor that issued it.
- R4: A response entered on memory port m with `mem_rsp_dest` = p leaves on processor port p with its data and write flag unchanged, and `cpu_rsp_mod` equals m.
- R5: An uncontended packet is accepted at one clock edge and is visible at the far side after exactly log2(N) = 3 edges. The output valid is still low one edge earlier.
- R6: An output that is valid while its ready is low stays valid, and its contents stay unchanged, until it is accepted. Packets that queue behind it on the same path come out later, in issue order, each exactly once.
- R7: Processors p and p+N/2 meet in the same first-column switch. When both need the same output in the same cycle, only one sees ready high and the other is accepted on the next edge. The first contest after reset goes to the upper input (the lower processor number), and each later contest at that output goes to the input that lost the previous one.
- R8: `rst_n` low clears the network asynchronously. No output valid is high after a reset edge, and packets in flight at reset never appear.
- R9: With a blocked memory port and log2(N) packets already queued on the path, the issuing processor sees ready low.
- R10: When all processors send at once with destination module = p XOR c, all of them see ready high in the same cycle, and all packets arrive together 3 edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | NPORT | Request present, one bit per processor |
| cpu_req_ready | output | NPORT | Request taken this edge; meaningful only while valid |
| cpu_req_wr | input | NPORT | Write flag per processor |
| cpu_req_addr | input | NPORT x ADDR_W | Byte address; bits BYTE_OFF upward pick the module |
| cpu_req_data | input | NPORT x DATA_W | Request data |
| mem_req_valid | output | NPORT | Request present at module port |
| mem_req_ready | input | NPORT | Module accepts the request |
| mem_req_wr | output | NPORT | Delivered write flag |
| mem_req_addr | output | NPORT x ADDR_W | Delivered byte address |
| mem_req_data | output | NPORT x DATA_W | Delivered data |
| mem_req_src | output | NPORT x log2(NPORT) | Rewritten route field = issuing processor |
| mem_rsp_valid | input | NPORT | Response present from module |
| mem_rsp_ready | output | NPORT | Response taken this edge; meaningful only while valid |
| mem_rsp_wr | input | NPORT | Response write flag |
| mem_rsp_dest | input | NPORT x log2(NPORT) | Processor to return to |
| mem_rsp_data | input | NPORT x DATA_W | Response data |
| cpu_rsp_valid | output | NPORT | Response present at processor port |
| cpu_rsp_ready | input | NPORT | Processor accepts the response |
| cpu_rsp_wr | output | NPORT | Delivered response write flag |
| cpu_rsp_data | output | NPORT x DATA_W | Delivered response data |
| cpu_rsp_mod | output | NPORT x log2(NPORT) | Module that produced the response |

## Verification
The hold properties expect nothing from the sources. They rely only on the sinks being free to lower ready, which the stimulus does on purpose at one memory port and one processor port. The route property needs only that an address delivered on a module port was issued with that module's bits. This holds for any source, because the network has no other way to choose a port. The stimulus changes inputs only between clock edges. It withdraws a request only after the request has been accepted, with one exception: a request that is offered while the path is full and is never admitted, which is how the full-path case is shown.

// File: rtl/omega_net.sv
module omega_net #(
  parameter int NPORT    = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int BYTE_OFF = 2,
  localparam int SEL_W   = $clog2(NPORT)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NPORT-1:0]                   cpu_req_valid,
  output logic [NPORT-1:0]                   cpu_req_ready,
  input  logic [NPORT-1:0]                   cpu_req_wr,
  input  logic [NPORT-1:0][ADDR_W-1:0]       cpu_req_addr,
  input  logic [NPORT-1:0][DATA_W-1:0]       cpu_req_data,
  output logic [NPORT-1:0]                   mem_req_valid,
  input  logic [NPORT-1:0]                   mem_req_ready,
  output logic [NPORT-1:0]                   mem_req_wr,
  output logic [NPORT-1:0][ADDR_W-1:0]       mem_req_addr,
  output logic [NPORT-1:0][DATA_W-1:0]       mem_req_data,
  output logic [NPORT-1:0][SEL_W-1:0]        mem_req_src,
  input  logic [NPORT-1:0]                   mem_rsp_valid,
  output logic [NPORT-1:0]                   mem_rsp_ready,
  input  logic [NPORT-1:0]                   mem_rsp_wr,
  input  logic [NPORT-1:0][SEL_W-1:0]        mem_rsp_dest,
  input  logic [NPORT-1:0][DATA_W-1:0]       mem_rsp_data,
  output logic [NPORT-1:0]                   cpu_rsp_valid,
  input  logic [NPORT-1:0]                   cpu_rsp_ready,
  output logic [NPORT-1:0]                   cpu_rsp_wr,
  output logic [NPORT-1:0][DATA_W-1:0]       cpu_rsp_data,
  output logic [NPORT-1:0][SEL_W-1:0]        cpu_rsp_mod
);

  localparam int STG  = SEL_W;
  localparam int HALF = NPORT / 2;

  // g = 0: request direction, g = 1: response direction
  for (genvar g = 0; g < 2; g++) begin : g_net
    localparam int PLW = (g == 0) ? (1 + ADDR_W + DATA_W) : (1 + DATA_W);

    logic             vld [0:STG][0:NPORT-1];
    logic             rdy [0:STG][0:NPORT-1];
    logic [SEL_W-1:0] rte [0:STG][0:NPORT-1];
    logic [PLW-1:0]   pay [0:STG][0:NPORT-1];

    for (genvar i = 0; i < NPORT; i++) begin : g_edge
      if (g == 0) begin : g_req
        assign vld[0][i]        = cpu_req_valid[i];
        assign rte[0][i]        = cpu_req_addr[i][BYTE_OFF +: SEL_W];
        assign pay[0][i]        = {cpu_req_wr[i], cpu_req_addr[i], cpu_req_data[i]};
        assign cpu_req_ready[i] = rdy[0][i];
        assign mem_req_valid[i] = vld[STG][i];
        assign rdy[STG][i]      = mem_req_ready[i];
        assign mem_req_src[i]   = rte[STG][i];
        assign {mem_req_wr[i], mem_req_addr[i], mem_req_data[i]} = pay[STG][i];
      end else begin : g_rsp
        assign vld[0][i]        = mem_rsp_valid[i];
        assign rte[0][i]        = mem_rsp_dest[i];
        assign pay[0][i]        = {mem_rsp_wr[i], mem_rsp_data[i]};
        assign mem_rsp_ready[i] = rdy[0][i];
        assign cpu_rsp_valid[i] = vld[STG][i];
        assign rdy[STG][i]      = cpu_rsp_ready[i];
        assign cpu_rsp_mod[i]   = rte[STG][i];
        assign {cpu_rsp_wr[i], cpu_rsp_data[i]} = pay[STG][i];
      end
    end

    for (genvar s = 0; s < STG; s++) begin : g_stg
      localparam int BP = SEL_W - 1 - s;

      // perfect shuffle: switch k takes lines k and k+HALF
      for (genvar k = 0; k < HALF; k++) begin : g_sw
        logic [1:0]       iv;
        logic [1:0]       ig;
        logic [1:0]       dir;
        logic [1:0]       takev;
        logic [1:0]       pickv;
        logic [SEL_W-1:0] ir [2];
        logic [PLW-1:0]   ip [2];

        assign iv[0]  = vld[s][k];
        assign iv[1]  = vld[s][k+HALF];
        assign ir[0]  = rte[s][k];
        assign ir[1]  = rte[s][k+HALF];
        assign ip[0]  = pay[s][k];
        assign ip[1]  = pay[s][k+HALF];
        assign dir[0] = ir[0][BP];
        assign dir[1] = ir[1][BP];

        assign ig[0] = iv[0] && takev[dir[0]] && !pickv[dir[0]];
        assign ig[1] = iv[1] && takev[dir[1]] &&  pickv[dir[1]];
        assign rdy[s][k]      = ig[0];
        assign rdy[s][k+HALF] = ig[1];

        for (genvar o = 0; o < 2; o++) begin : g_out
          logic             w0, w1, pick, ld, ov, turn;
          logic [SEL_W-1:0] ort, nrt;
          logic [PLW-1:0]   opl;

          assign w0   = iv[0] && (dir[0] == 1'(o));
          assign w1   = iv[1] && (dir[1] == 1'(o));
          assign ld   = !ov || rdy[s+1][2*k+o];
          assign pick = w1 && (!w0 || turn);
          assign takev[o] = ld && (w0 || w1);
          assign pickv[o] = pick;

          always_comb begin
            nrt     = pick ? ir[1] : ir[0];
            nrt[BP] = pick;
          end

          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
              ov   <= 1'b0;
              turn <= 1'b0;
            end else begin
              if (ld) ov <= w0 || w1;
              if (ld && w0 && w1) turn <= !pick;
            end
          end

          always_ff @(posedge clk) begin
            if (takev[o]) begin
              ort <= nrt;
              opl <= pick ? ip[1] : ip[0];
            end
          end

          assign vld[s+1][2*k+o] = ov;
          assign rte[s+1][2*k+o] = ort;
          assign pay[s+1][2*k+o] = opl;
        end
      end
    end
  end

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int NPORT    = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int BYTE_OFF = 2,
  localparam int SEL_W   = $clog2(NPORT)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPORT-1:0]             mem_req_valid,
  input logic [NPORT-1:0]             mem_req_ready,
  input logic [NPORT-1:0][ADDR_W-1:0] mem_req_addr,
  input logic [NPORT-1:0][DATA_W-1:0] mem_req_data,
  input logic [NPORT-1:0][SEL_W-1:0]  mem_req_src,
  input logic [NPORT-1:0]             cpu_rsp_valid,
  input logic [NPORT-1:0]             cpu_rsp_ready,
  input logic [NPORT-1:0][DATA_W-1:0] cpu_rsp_data,
  input logic [NPORT-1:0][SEL_W-1:0]  cpu_rsp_mod
);

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid[i] && !mem_req_ready[i] |=>
        mem_req_valid[i] && $stable(mem_req_addr[i]) &&
        $stable(mem_req_data[i]) && $stable(mem_req_src[i]));

    // R6
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid[i] && !cpu_rsp_ready[i] |=>
        cpu_rsp_valid[i] && $stable(cpu_rsp_data[i]) && $stable(cpu_rsp_mod[i]));

    // R1
    mem_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid[i] |-> mem_req_addr[i][BYTE_OFF +: SEL_W] == SEL_W'(i));
  end

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (mem_req_valid == '0) && (cpu_rsp_valid == '0));

endmodule

bind omega_net omega_net_chk #(
  .NPORT(NPORT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_OFF(BYTE_OFF)
) i_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
  .mem_req_src(mem_req_src),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
  .cpu_rsp_data(cpu_rsp_data), .cpu_rsp_mod(cpu_rsp_mod)
);

// File: tb/test_omega_net.sv
`timescale 1ns/1ps
module test_omega_net;
  localparam int N  = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         cpu_req_valid, cpu_req_ready, cpu_req_wr;
  logic [N-1:0][31:0]   cpu_req_addr, cpu_req_data;
  logic [N-1:0]         mem_req_valid, mem_req_ready, mem_req_wr;
  logic [N-1:0][31:0]   mem_req_addr, mem_req_data;
  logic [N-1:0][SW-1:0] mem_req_src;
  logic [N-1:0]         mem_rsp_valid, mem_rsp_ready, mem_rsp_wr;
  logic [N-1:0][SW-1:0] mem_rsp_dest;
  logic [N-1:0][31:0]   mem_rsp_data;
  logic [N-1:0]         cpu_rsp_valid, cpu_rsp_ready, cpu_rsp_wr;
  logic [N-1:0][31:0]   cpu_rsp_data;
  logic [N-1:0][SW-1:0] cpu_rsp_mod;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  omega_net i_omega_net (.*);

  // {source processor, byte address, data, write flag}
  localparam logic [67:0] VEC [10] = '{
    {3'd1, 32'h0000_0100, 32'h1111_0000, 1'b0},
    {3'd6, 32'h0000_0104, 32'h2222_0001, 1'b1},
    {3'd3, 32'h0000_0108, 32'h3333_0002, 1'b0},
    {3'd0, 32'h0000_010C, 32'h4444_0003, 1'b1},
    {3'd7, 32'h0000_0110, 32'h5555_0004, 1'b0},
    {3'd2, 32'h0000_0114, 32'h6666_0005, 1'b1},
    {3'd4, 32'h0000_0118, 32'h7777_0006, 1'b0},
    {3'd5, 32'h0000_011C, 32'h8888_0007, 1'b1},
    {3'd5, 32'h0000_0ABF, 32'h9999_0008, 1'b0},
    {3'd7, 32'hFFFF_FFE8, 32'hAAAA_0009, 1'b1}
  };

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cpu_req_valid = '0; cpu_req_wr = '0; cpu_req_addr = '0; cpu_req_data = '0;
    mem_req_ready = '1;
    mem_rsp_valid = '0; mem_rsp_wr = '0; mem_rsp_dest = '0; mem_rsp_data = '0;
    cpu_rsp_ready = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle after reset
    check(mem_req_valid == '0, "R8 mem valid after reset", 64'(mem_req_valid), 0);
    check(cpu_rsp_valid == '0, "R8 rsp valid after reset", 64'(cpu_rsp_valid), 0);

    // vector table: round trip for each entry (R1 R2 R3 R4 R5)
    for (int v = 0; v < 10; v++) begin
      logic [2:0] p; logic [31:0] a; logic [31:0] d; logic w; int m;
      {p, a, d, w} = VEC[v];
      m = int'(a[4:2]);
      @(negedge clk);
      cpu_req_valid[p] = 1'b1; cpu_req_addr[p] = a; cpu_req_data[p] = d; cpu_req_wr[p] = w;
      @(negedge clk);
      cpu_req_valid[p] = 1'b0;
      @(negedge clk);
      check(mem_req_valid == '0, "R5 request not early", 64'(mem_req_valid), 0);
      @(negedge clk);
      check(mem_req_valid == (8'd1 << m), "R1 R2 module port", 64'(mem_req_valid), 64'(8'd1 << m));
      check(mem_req_addr[m] == a && mem_req_data[m] == d && mem_req_wr[m] == w,
            "R1 payload", {mem_req_addr[m], mem_req_data[m]}, {a, d});
      check(mem_req_src[m] == p, "R3 source field", 64'(mem_req_src[m]), 64'(p));
      mem_rsp_valid[m] = 1'b1; mem_rsp_dest[m] = p; mem_rsp_data[m] = ~d; mem_rsp_wr[m] = w;
      @(negedge clk);
      mem_rsp_valid[m] = 1'b0;
      @(negedge clk);
      check(cpu_rsp_valid == '0, "R5 response not early", 64'(cpu_rsp_valid), 0);
      @(negedge clk);
      check(cpu_rsp_valid == (8'd1 << p), "R4 processor port", 64'(cpu_rsp_valid), 64'(8'd1 << p));
      check(cpu_rsp_data[p] == ~d && cpu_rsp_wr[p] == w, "R4 response payload",
            64'(cpu_rsp_data[p]), 64'(~d));
      check(cpu_rsp_mod[p] == SW'(m), "R4 module field", 64'(cpu_rsp_mod[p]), 64'(m));
    end

    // R10: xor permutation, conflict free
    @(negedge clk);
    for (int p = 0; p < N; p++) begin
      cpu_req_valid[p] = 1'b1; cpu_req_wr[p] = 1'b0;
      cpu_req_addr[p] = 32'h2000 | (32'(p ^ 5) << 2);
      cpu_req_data[p] = 32'hC0DE_0000 + 32'(p);
    end
    #1;
    check(cpu_req_ready == 8'hFF, "R10 all ready", 64'(cpu_req_ready), 64'hFF);
    @(negedge clk);
    cpu_req_valid = '0;
    @(negedge clk);
    @(negedge clk);
    check(mem_req_valid == 8'hFF, "R10 all delivered", 64'(mem_req_valid), 64'hFF);
    for (int m = 0; m < N; m++)
      check(mem_req_src[m] == SW'(m ^ 5) && mem_req_data[m] == 32'hC0DE_0000 + 32'(m ^ 5),
            "R10 R3 permutation", 64'(mem_req_src[m]), 64'(m ^ 5));

    // R7: processors 0 and 4 both to module 0
    for (int r = 0; r < 2; r++) begin
      int win; int lose;
      win  = (r == 0) ? 0 : 4;
      lose = (r == 0) ? 4 : 0;
      @(negedge clk);
      cpu_req_valid[0] = 1'b1; cpu_req_addr[0] = 32'h40; cpu_req_data[0] = 32'hA0;
      cpu_req_valid[4] = 1'b1; cpu_req_addr[4] = 32'h60; cpu_req_data[4] = 32'hA4;
      #1;
      check(cpu_req_ready[win] == 1'b1 && cpu_req_ready[lose] == 1'b0, "R7 one winner",
            64'(cpu_req_ready), 64'(8'd1 << win));
      @(negedge clk);
      cpu_req_valid[win] = 1'b0;
      #1;
      check(cpu_req_ready[lose] == 1'b1, "R7 loser next cycle", 64'(cpu_req_ready[lose]), 1);
      @(negedge clk);
      cpu_req_valid[lose] = 1'b0;
      @(negedge clk);
      check(mem_req_valid[0] && mem_req_src[0] == SW'(win), "R7 winner first",
            64'(mem_req_src[0]), 64'(win));
      @(negedge clk);
      check(mem_req_valid[0] && mem_req_src[0] == SW'(lose), "R7 loser second",
            64'(mem_req_src[0]), 64'(lose));
    end

    // R6 R9: blocked module 3, processor 2 fills the path
    @(negedge clk);
    mem_req_ready[3] = 1'b0;
    cpu_req_valid[2] = 1'b1; cpu_req_addr[2] = 32'h0C; cpu_req_data[2] = 32'hAAAA;
    @(negedge clk);
    cpu_req_addr[2] = 32'h2C; cpu_req_data[2] = 32'hBBBB;
    @(negedge clk);
    cpu_req_addr[2] = 32'h4C; cpu_req_data[2] = 32'hCCCC;
    @(negedge clk);
    cpu_req_addr[2] = 32'h6C; cpu_req_data[2] = 32'hDDDD;
    #1;
    check(cpu_req_ready[2] == 1'b0, "R9 full path not ready", 64'(cpu_req_ready[2]), 0);
    check(mem_req_valid[3] && mem_req_data[3] == 32'hAAAA, "R6 head present",
          64'(mem_req_data[3]), 64'hAAAA);
    @(negedge clk);
    cpu_req_valid[2] = 1'b0;
    @(negedge clk);
    check(mem_req_valid[3] && mem_req_data[3] == 32'hAAAA, "R6 head held",
          64'(mem_req_data[3]), 64'hAAAA);
    mem_req_ready[3] = 1'b1;
    @(negedge clk);
    check(mem_req_valid[3] && mem_req_data[3] == 32'hBBBB, "R6 second in order",
          64'(mem_req_data[3]), 64'hBBBB);
    @(negedge clk);
    check(mem_req_valid[3] && mem_req_data[3] == 32'hCCCC, "R6 third in order",
          64'(mem_req_data[3]), 64'hCCCC);
    @(negedge clk);
    check(mem_req_valid[3] == 1'b0, "R6 no duplicate", 64'(mem_req_valid[3]), 0);

    // R6: blocked processor 6 on the response side
    cpu_rsp_ready[6] = 1'b0;
    mem_rsp_valid[1] = 1'b1; mem_rsp_dest[1] = 3'd6; mem_rsp_data[1] = 32'hBEEF_0006;
    @(negedge clk);
    mem_rsp_valid[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(cpu_rsp_valid[6] && cpu_rsp_data[6] == 32'hBEEF_0006, "R6 response arrives",
          64'(cpu_rsp_data[6]), 64'hBEEF_0006);
    @(negedge clk);
    @(negedge clk);
    check(cpu_rsp_valid[6] && cpu_rsp_data[6] == 32'hBEEF_0006 && cpu_rsp_mod[6] == 3'd1,
          "R6 response held", 64'(cpu_rsp_data[6]), 64'hBEEF_0006);
    cpu_rsp_ready[6] = 1'b1;
    @(negedge clk);
    check(cpu_rsp_valid[6] == 1'b0, "R6 response once", 64'(cpu_rsp_valid[6]), 0);

    // R8: reset while a request is in flight
    @(negedge clk);
    cpu_req_valid[3] = 1'b1; cpu_req_addr[3] = 32'h18; cpu_req_data[3] = 32'h5EED;
    @(negedge clk);
    cpu_req_valid[3] = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req_valid == '0, "R8 in-flight dropped", 64'(mem_req_valid), 0);
    @(negedge clk);
    check(mem_req_valid == '0 && cpu_rsp_valid == '0, "R8 stays idle",
          64'(mem_req_valid), 0);

    summary();
    $finish;
  end
endmodule